// File: doc/BRIEF.md
# External Pin and Keypad Interrupt Request Flags

This block produces the raw interrupt request flags for two active-low external interrupt pins and for an eight-input keypad port. An interrupt controller around it resolves priority and vectoring. This block only raises, holds and drops the flags. Every pin input first passes through a two-flop synchroniser, so asynchronous pins are safe to connect directly.

Each external channel has a trigger-type input.

- **Edge mode (type bit 1).** A falling edge on the pin raises a sticky flag. The controller's vector-acknowledge pulse clears it, and software can write it. A falling edge that coincides with an acknowledge wins, so no event is lost.
- **Level mode (type bit 0).** The flag is simply the inverse of the synchronised pin. Acknowledge and software writes have no effect.

The keypad flag works differently. Any keypad pin whose mask bit is 1 being low sets the flag. Only a software write clears it. If an enabled pin is still low when software clears the flag, the flag rises again one cycle later.

Each external channel is a state machine with four states:

- `E_IDLE`: edge mode, no request.
- `E_PEND`: edge mode, request held.
- `L_QUIET`: level mode, pin high.
- `L_ACTIVE`: level mode, pin low.

External channel transitions:

- **fall**: any state to `E_PEND` in edge mode.
- **sw-set**: to `E_PEND`.
- **sw-clear**: to `E_IDLE`.
- **ack**: `E_PEND` to `E_IDLE`.
- **hold**: the state stays where it is.
- **level-follow**: to `L_ACTIVE` or `L_QUIET` from the pin whenever the type bit is 0.
- **mode switch to edge**: `L_ACTIVE` maps to `E_PEND` and `L_QUIET` maps to `E_IDLE`.

The keypad machine has two states, `K_CLEAR` and `K_SET`. Its transitions are:

- **press**: `K_CLEAR` to `K_SET`.
- **sw-clear**: `K_SET` to `K_CLEAR`.
- **sw-set**: `K_CLEAR` to `K_SET`.

Top module: `irq_flag_unit`

## Requirements
- R1: A pin change reaches the flags through a two-flop synchroniser. A pin driven between clock edges P0 and P1 first affects a flag at edge P3, and not at P2.
- R2: In edge mode (type bit = 1), a synchronised high-then-low pin sample sets that channel's flag. A rising edge leaves the flag unchanged.
- R3: In edge mode, an acknowledge pulse on bit i of `ext_ack` clears flag i at the next clock edge.
- R4: In edge mode, when a falling edge and an acknowledge occur in the same cycle, the flag remains set.
- R5: In level mode (type bit = 0), the flag equals the inverse of the synchronised pin. Acknowledge pulses do not change it.
- R6: In edge mode, when there is no falling edge, a software write (`ext_sw_we[i]` = 1) loads flag i with `ext_sw_wdata[i]`.
- R7: The keypad flag sets when any keypad pin whose mask bit is 1 is low. Low pins whose mask bit is 0 are ignored.
- R8: Once set, the keypad flag stays set after the pins return high, until a software write of 0 clears it.
- R9: If software clears the keypad flag while an enabled pin is still low, the flag reads 0 for one cycle and then reads 1 again.
- R10: After reset, all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_n | input | 2 | Active-low external interrupt pins |
| ext_edge_sel | input | 2 | Per-channel trigger type: 1 = falling edge, 0 = low level |
| ext_ack | input | 2 | Vector-acknowledge pulses, one per channel |
| ext_sw_we | input | 2 | Software write strobe for each external flag |
| ext_sw_wdata | input | 2 | Software write value for each external flag |
| kpd_pin | input | 8 | Keypad input port |
| kpd_mask | input | 8 | Keypad enable mask, 1 = pin may raise the flag |
| kpd_sw_we | input | 1 | Software write strobe for the keypad flag |
| kpd_sw_wdata | input | 1 | Software write value for the keypad flag |
| ext_flag | output | 2 | External interrupt request flags |
| kpd_flag | output | 1 | Keypad interrupt request flag |

## Verification
The embedded assertions check the following on every cycle:

- A detected falling edge in edge mode is always followed by a set flag.
- An acknowledge with no competing edge or write always clears the flag.
- Level mode mirrors the inverted synchronised pin one cycle later.
- A keypad write always takes effect.
- An enabled low keypad pin always sets the flag.

Only the bench's scenarios can show the properties that rest on the timing of external stimulus:

- The exact three-edge latency through the synchroniser.
- That masked pins and rising edges leave the flags alone.
- The one-cycle dip of the keypad flag when it is cleared while a pin is still low.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

    typedef enum logic [1:0] {
        E_IDLE   = 2'd0,
        E_PEND   = 2'd1,
        L_QUIET  = 2'd2,
        L_ACTIVE = 2'd3
    } ext_state_e;

    typedef enum logic {
        K_CLEAR = 1'b0,
        K_SET   = 1'b1
    } kpd_state_e;

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stg_q [STAGES];

    // Idle level of every pin is high, so stages reset to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= '1;
        else        stg_q[0] <= d_async;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= '1;
            else        stg_q[s] <= stg_q[s-1];
        end
    end

    assign q_sync = stg_q[STAGES-1];
endmodule

// File: rtl/irq_ext_chan.sv
module irq_ext_chan
    import irq_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic edge_mode,
    input  logic ack,
    input  logic sw_we,
    input  logic sw_wdata,
    output logic flag_o
);
    ext_state_e state_q, state_d;
    logic       prev_q;
    logic       fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= pin_s;
    end

    assign fall = prev_q & ~pin_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= E_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!edge_mode) begin
            state_d = pin_s ? L_QUIET : L_ACTIVE;
        end else if (fall) begin
            state_d = E_PEND;
        end else if (sw_we) begin
            state_d = sw_wdata ? E_PEND : E_IDLE;
        end else if (ack) begin
            state_d = E_IDLE;
        end else begin
            unique case (state_q)
                E_IDLE, L_QUIET:  state_d = E_IDLE;
                E_PEND, L_ACTIVE: state_d = E_PEND;
                default:          state_d = E_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            E_PEND, L_ACTIVE: flag_o = 1'b1;
            E_IDLE, L_QUIET:  flag_o = 1'b0;
            default:          flag_o = 1'b0;
        endcase
    end

    // R2
    edge_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && fall) |=> flag_o);

    // R3
    ack_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && ack && !fall && !sw_we) |=> !flag_o);

    // R5
    level_follows_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode) |=> (flag_o == !$past(pin_s)));

    // R6
    sw_write_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && sw_we && !fall) |=> (flag_o == $past(sw_wdata)));
endmodule

// File: rtl/irq_kpd_flag.sv
module irq_kpd_flag
    import irq_flag_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_s,
    input  logic [WIDTH-1:0] mask,
    input  logic             sw_we,
    input  logic             sw_wdata,
    output logic             flag_o
);
    kpd_state_e state_q, state_d;
    logic       any_low;

    assign any_low = |(~pins_s & mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= K_CLEAR;
        else        state_q <= state_d;
    end

    // A software write wins its cycle; a still-low pin re-sets the flag on the next one.
    always_comb begin
        state_d = state_q;
        if (sw_we) begin
            state_d = sw_wdata ? K_SET : K_CLEAR;
        end else begin
            unique case (state_q)
                K_CLEAR: state_d = any_low ? K_SET : K_CLEAR;
                K_SET:   state_d = K_SET;
                default: state_d = K_CLEAR;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            K_SET:   flag_o = 1'b1;
            K_CLEAR: flag_o = 1'b0;
            default: flag_o = 1'b0;
        endcase
    end

    // R7
    kpd_press_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_low && !sw_we) |=> flag_o);

    // R8
    kpd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !sw_we) |=> flag_o);

    // R8
    kpd_sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> (flag_o == $past(sw_wdata)));
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit #(
    parameter int NUM_EXT     = 2,
    parameter int KPD_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] ext_pin_n,
    input  logic [NUM_EXT-1:0] ext_edge_sel,
    input  logic [NUM_EXT-1:0] ext_ack,
    input  logic [NUM_EXT-1:0] ext_sw_we,
    input  logic [NUM_EXT-1:0] ext_sw_wdata,
    input  logic [KPD_W-1:0]   kpd_pin,
    input  logic [KPD_W-1:0]   kpd_mask,
    input  logic               kpd_sw_we,
    input  logic               kpd_sw_wdata,
    output logic [NUM_EXT-1:0] ext_flag,
    output logic               kpd_flag
);
    logic [NUM_EXT-1:0] ext_s;
    logic [KPD_W-1:0]   kpd_s;

    irq_pin_sync #(.WIDTH(NUM_EXT), .STAGES(SYNC_STAGES)) u_ext_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ext_pin_n),
        .q_sync  (ext_s)
    );

    irq_pin_sync #(.WIDTH(KPD_W), .STAGES(SYNC_STAGES)) u_kpd_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (kpd_pin),
        .q_sync  (kpd_s)
    );

    for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
        irq_ext_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_s     (ext_s[i]),
            .edge_mode (ext_edge_sel[i]),
            .ack       (ext_ack[i]),
            .sw_we     (ext_sw_we[i]),
            .sw_wdata  (ext_sw_wdata[i]),
            .flag_o    (ext_flag[i])
        );
    end

    irq_kpd_flag #(.WIDTH(KPD_W)) u_kpd (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins_s   (kpd_s),
        .mask     (kpd_mask),
        .sw_we    (kpd_sw_we),
        .sw_wdata (kpd_sw_wdata),
        .flag_o   (kpd_flag)
    );

    // R10
    reset_flags_low_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (ext_flag == '0 && !kpd_flag));
endmodule

// File: tb/test_irq_flag_unit.sv
`timescale 1ns/1ps
module test_irq_flag_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ext_pin_n = 2'b11;
    logic [1:0] ext_edge_sel = 2'b11;
    logic [1:0] ext_ack = 2'b00;
    logic [1:0] ext_sw_we = 2'b00;
    logic [1:0] ext_sw_wdata = 2'b00;
    logic [7:0] kpd_pin = 8'hFF;
    logic [7:0] kpd_mask = 8'h00;
    logic       kpd_sw_we = 1'b0;
    logic       kpd_sw_wdata = 1'b0;
    logic [1:0] ext_flag;
    logic       kpd_flag;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        string      tag;
        logic [1:0] ext;
        logic       kpd;
    } exp_item_t;

    exp_item_t sbq [$];

    always #2.5 clk = ~clk;

    irq_flag_unit i_irq_flag_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_pin_n    (ext_pin_n),
        .ext_edge_sel (ext_edge_sel),
        .ext_ack      (ext_ack),
        .ext_sw_we    (ext_sw_we),
        .ext_sw_wdata (ext_sw_wdata),
        .kpd_pin      (kpd_pin),
        .kpd_mask     (kpd_mask),
        .kpd_sw_we    (kpd_sw_we),
        .kpd_sw_wdata (kpd_sw_wdata),
        .ext_flag     (ext_flag),
        .kpd_flag     (kpd_flag)
    );

    // Monitor: compares queued expectations away from the active edge.
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            exp_item_t it;
            it = sbq.pop_front();
            n_checks++;
            if (ext_flag !== it.ext || kpd_flag !== it.kpd) begin
                n_fail++;
                $display("FAIL %s: ext_flag=%b kpd_flag=%b expected ext_flag=%b kpd_flag=%b",
                         it.tag, ext_flag, kpd_flag, it.ext, it.kpd);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_flags(input string tag, input logic [1:0] e_ext, input logic e_kpd);
        exp_item_t it;
        it.tag = tag;
        it.ext = e_ext;
        it.kpd = e_kpd;
        sbq.push_back(it);
    endtask

    task automatic pulse_ack(input int ch);
        ext_ack[ch] = 1'b1;
        step(1);
        ext_ack[ch] = 1'b0;
    endtask

    task automatic ext_write(input int ch, input logic v);
        ext_sw_we[ch] = 1'b1;
        ext_sw_wdata[ch] = v;
        step(1);
        ext_sw_we[ch] = 1'b0;
    endtask

    task automatic kpd_write(input logic v);
        kpd_sw_we = 1'b1;
        kpd_sw_wdata = v;
        step(1);
        kpd_sw_we = 1'b0;
    endtask

    task automatic finish_run();
        @(negedge clk);
        #0.5;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: run hung, cycles=%0d expected below 20000", cyc);
                finish_run();
            end
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        expect_flags("R10 reset state", 2'b00, 1'b0);

        // R1 / R2: falling edge on channel 0, edge mode
        ext_pin_n[0] = 1'b0;
        step(2);
        expect_flags("R1 not yet through synchroniser", 2'b00, 1'b0);
        step(1);
        expect_flags("R2 falling edge sets ch0", 2'b01, 1'b0);
        ext_pin_n[0] = 1'b1;
        step(4);
        expect_flags("R2 rising edge leaves ch0", 2'b01, 1'b0);

        // R3 acknowledge clears
        pulse_ack(0);
        expect_flags("R3 ack clears ch0", 2'b00, 1'b0);

        // R4 edge and ack coincide on channel 1
        ext_pin_n[1] = 1'b0;
        step(2);
        ext_ack[1] = 1'b1;
        step(1);
        ext_ack[1] = 1'b0;
        expect_flags("R4 edge beats ack on ch1", 2'b10, 1'b0);
        pulse_ack(1);
        expect_flags("R3 ack clears ch1", 2'b00, 1'b0);
        ext_pin_n[1] = 1'b1;
        step(4);

        // R6 software writes
        ext_write(0, 1'b1);
        expect_flags("R6 software set ch0", 2'b01, 1'b0);
        ext_write(0, 1'b0);
        expect_flags("R6 software clear ch0", 2'b00, 1'b0);

        // R5 level mode on channel 1
        ext_edge_sel[1] = 1'b0;
        step(2);
        expect_flags("R5 level mode pin high", 2'b00, 1'b0);
        ext_pin_n[1] = 1'b0;
        step(3);
        expect_flags("R5 level mode pin low", 2'b10, 1'b0);
        pulse_ack(1);
        expect_flags("R5 ack ignored in level mode", 2'b10, 1'b0);
        ext_pin_n[1] = 1'b1;
        step(2);
        expect_flags("R1 level release latency", 2'b10, 1'b0);
        step(1);
        expect_flags("R5 level flag follows pin high", 2'b00, 1'b0);
        ext_edge_sel[1] = 1'b1;
        step(2);

        // R7 masked pin ignored, enabled pin sets
        kpd_mask = 8'h0F;
        kpd_pin[6] = 1'b0;
        step(4);
        expect_flags("R7 masked keypad pin ignored", 2'b00, 1'b0);
        kpd_pin[6] = 1'b1;
        kpd_pin[2] = 1'b0;
        step(2);
        expect_flags("R1 keypad latency", 2'b00, 1'b0);
        step(1);
        expect_flags("R7 enabled keypad pin sets", 2'b00, 1'b1);
        kpd_pin[2] = 1'b1;
        step(4);
        expect_flags("R8 keypad flag sticky", 2'b00, 1'b1);
        kpd_write(1'b0);
        expect_flags("R8 software clears keypad", 2'b00, 1'b0);

        // R9 clear while an enabled pin is still low
        kpd_pin[3] = 1'b0;
        step(3);
        expect_flags("R7 pin3 sets keypad", 2'b00, 1'b1);
        kpd_write(1'b0);
        expect_flags("R9 cleared for one cycle", 2'b00, 1'b0);
        step(1);
        expect_flags("R9 re-set while pin low", 2'b00, 1'b1);
        kpd_pin[3] = 1'b1;
        step(3);
        kpd_write(1'b0);
        step(1);
        expect_flags("R8 stays clear after release", 2'b00, 1'b0);

        done = 1'b1;
        finish_run();
    end
endmodule